// File: doc/BRIEF.md
# Two-Player Dice Race Controller

This block sequences a two-player dice race to a target score. A counter cycling through the faces 1 to 6 stands in for the die. It advances one face per clock while the roll button is held, and the face showing when the button is let go is the roll. Each roll other than a 1 adds to a running turn subtotal. A 1 voids the turn and hands play to the other side. Pressing hold banks the subtotal into the active player's total and passes the turn, or declares a win once that total reaches the target.

The block holds the die face, a 7-bit turn subtotal, one 7-bit total per player, and two one-bit flags: one for the player who starts the current game and one for the player whose turn it is. The outputs are binary values and two player lamps. Display decoding is left to the logic outside. After a win, the winner's lamp follows an external blink enable. A new-game request clears both totals and gives the opening turn to the other player. All buttons are taken as synchronized and debounced.

Top module: `dice_duel_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the die face to 0, the subtotal and both totals to 0, and the starting-player flag to player 1. After reset, lamp 1 is on and lamp 2 is off.
- R2: The die advances by one face on each clock while ROLL is held during a roll. From 0 it goes to 1, and from 6 it goes back to 1. It holds its value on every other clock.
- R3: The first roll of a turn clears the subtotal in the clock that ROLL is first seen, so no score carries over from an earlier turn.
- R4: Releasing ROLL with a face other than 1 adds that face to the subtotal in the same clock. The sum saturates at 127.
- R5: Releasing ROLL on face 1 adds nothing to either total and passes the turn to the other player.
- R6: While the controller waits between rolls, ROLL takes precedence over HOLD. HOLD with ROLL low adds the subtotal to the active player's total, and the sum saturates at 127.
- R7: One clock after the add, a total of 100 or more ends the game with the active player as winner. A lower total passes the turn.
- R8: Outside a won game, lamp 1 is the inverse of the active-player flag (0 = player 1) and lamp 2 equals it. In a won game, the winner's lamp follows BLINK and the other lamp is off.
- R9: NEW_GAME has effect only after a win. There it clears both totals and starts the next game with the opposite opening player. Anywhere else it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| roll | input | 1 | Roll button, held to spin the die |
| hold | input | 1 | Bank the subtotal and end the turn |
| new_game | input | 1 | Start a fresh game after a win |
| blink | input | 1 | Blink enable shown on the winner's lamp |
| die_face | output | 3 | Current die face, 0 after reset, then 1 to 6 |
| turn_sub | output | 7 | Turn subtotal |
| score_p1 | output | 7 | Player 1 total |
| score_p2 | output | 7 | Player 2 total |
| lamp_p1 | output | 1 | Player 1 lamp |
| lamp_p2 | output | 1 | Player 2 lamp |

## Verification
ROLL and HOLD can both be high in the same clock while the controller waits between rolls. The bench drives them together on purpose. It then checks that the die spins, that the roll result lands in the subtotal, and that no total changes. Both saturation limits are driven: a subtotal grown to 127 by repeated sixes, and a total of 13 plus 127. The win threshold is probed on both sides, with a total of 99 that must pass the turn and 101 that must win. NEW_GAME is pressed mid-game and must change nothing.

// File: rtl/dice_duel_pkg.sv
package dice_duel_pkg;

    parameter int SCORE_W = 7;
    parameter int DIE_W   = 3;

    typedef logic [SCORE_W-1:0] score_t;
    typedef logic [DIE_W-1:0]   face_t;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_BEGIN,
        ST_SPIN,
        ST_WAIT,
        ST_BANK,
        ST_BUST,
        ST_WON
    } phase_t;

    typedef struct packed {
        logic clr_tot;
        logic clr_sub;
        logic add_sub;
        logic add_tot;
        logic adv_die;
    } dp_ctrl_t;

    function automatic score_t sat_add(score_t a, score_t b);
        logic [SCORE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[SCORE_W] ? '1 : s[SCORE_W-1:0];
    endfunction

endpackage

// File: rtl/dd_die_counter.sv
module dd_die_counter
    import dice_duel_pkg::*;
#(
    parameter int FACES = 6
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    output face_t face
);
    localparam face_t TOP = face_t'(FACES);

    always_ff @(posedge clk) begin
        if (rst)
            face <= '0;
        else if (adv)
            face <= (face == TOP) ? face_t'(1) : face + face_t'(1);
    end

    assert_die_range_R2: assert property (@(posedge clk) disable iff (rst)
        face <= TOP);
    assert_die_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(face));
    assert_die_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (adv && face == TOP) |=> face == face_t'(1));

endmodule

// File: rtl/dd_score_regs.sv
module dd_score_regs
    import dice_duel_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr_tot,
    input  logic   clr_sub,
    input  logic   add_sub,
    input  logic   add_tot,
    input  logic   cp,
    input  face_t  face,
    output score_t sub,
    output score_t tot [2]
);
    always_ff @(posedge clk) begin
        if (rst || clr_sub)
            sub <= '0;
        else if (add_sub)
            sub <= sat_add(sub, score_t'(face));
    end

    assert_sub_grows_R4: assert property (@(posedge clk) disable iff (rst)
        !clr_sub |=> sub >= $past(sub));

    for (genvar p = 0; p < 2; p++) begin : g_player
        always_ff @(posedge clk) begin
            if (rst || clr_tot)
                tot[p] <= '0;
            else if (add_tot && (cp == 1'(p)))
                tot[p] <= sat_add(tot[p], sub);
        end

        assert_total_grows_R6: assert property (@(posedge clk) disable iff (rst)
            !clr_tot |=> tot[p] >= $past(tot[p]));
    end

endmodule

// File: rtl/dd_sequencer.sv
module dd_sequencer
    import dice_duel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     roll,
    input  logic     hold,
    input  logic     new_game,
    input  logic     face_one,
    input  logic     at_goal,
    output dp_ctrl_t ctl,
    output logic     cp,
    output phase_t   phase
);
    phase_t nxt;
    logic   fp;
    logic   load_cp, flip_cp, flip_fp;

    always_comb begin
        nxt     = phase;
        ctl     = '0;
        load_cp = 1'b0;
        flip_cp = 1'b0;
        flip_fp = 1'b0;
        case (phase)
            ST_INIT: begin
                ctl.clr_tot = 1'b1;
                load_cp     = 1'b1;
                nxt         = ST_BEGIN;
            end
            ST_BEGIN: if (roll) begin
                ctl.clr_sub = 1'b1;
                nxt         = ST_SPIN;
            end
            ST_SPIN: begin
                if (roll)
                    ctl.adv_die = 1'b1;
                else if (face_one)
                    nxt = ST_BUST;
                else begin
                    ctl.add_sub = 1'b1;
                    nxt         = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (roll)
                    nxt = ST_SPIN;
                else if (hold) begin
                    ctl.add_tot = 1'b1;
                    nxt         = ST_BANK;
                end
            end
            ST_BANK: begin
                if (at_goal)
                    nxt = ST_WON;
                else begin
                    flip_cp = 1'b1;
                    nxt     = ST_BEGIN;
                end
            end
            ST_BUST: begin
                flip_cp = 1'b1;
                nxt     = ST_BEGIN;
            end
            ST_WON: if (new_game) begin
                flip_fp = 1'b1;
                nxt     = ST_INIT;
            end
            default: nxt = ST_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= ST_INIT;
            cp    <= 1'b0;
            fp    <= 1'b0;
        end else begin
            phase <= nxt;
            if (load_cp)
                cp <= fp;
            else if (flip_cp)
                cp <= ~cp;
            if (flip_fp)
                fp <= ~fp;
        end
    end

    assert_bust_passes_R5: assert property (@(posedge clk) disable iff (rst)
        phase == ST_BUST |=> cp != $past(cp));
    assert_low_bank_passes_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_BANK && !at_goal) |=> cp != $past(cp));
    assert_win_keeps_player_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_BANK && at_goal) |=> (phase == ST_WON && $stable(cp)));

endmodule

// File: rtl/dice_duel_ctrl.sv
module dice_duel_ctrl
    import dice_duel_pkg::*;
#(
    parameter int FACES     = 6,
    parameter int WIN_SCORE = 100
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               roll,
    input  logic               hold,
    input  logic               new_game,
    input  logic               blink,
    output logic [DIE_W-1:0]   die_face,
    output logic [SCORE_W-1:0] turn_sub,
    output logic [SCORE_W-1:0] score_p1,
    output logic [SCORE_W-1:0] score_p2,
    output logic               lamp_p1,
    output logic               lamp_p2
);
    localparam score_t GOAL = score_t'(WIN_SCORE);

    dp_ctrl_t ctl;
    phase_t   phase;
    logic     cp;
    face_t    face;
    score_t   sub;
    score_t   tot [2];
    score_t   cur_tot;
    logic     at_goal, won;

    dd_die_counter #(.FACES(FACES)) u_die (
        .clk  (clk),
        .rst  (rst),
        .adv  (ctl.adv_die),
        .face (face)
    );

    dd_score_regs u_score (
        .clk     (clk),
        .rst     (rst),
        .clr_tot (ctl.clr_tot),
        .clr_sub (ctl.clr_sub),
        .add_sub (ctl.add_sub),
        .add_tot (ctl.add_tot),
        .cp      (cp),
        .face    (face),
        .sub     (sub),
        .tot     (tot)
    );

    dd_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .roll     (roll),
        .hold     (hold),
        .new_game (new_game),
        .face_one (face == face_t'(1)),
        .at_goal  (at_goal),
        .ctl      (ctl),
        .cp       (cp),
        .phase    (phase)
    );

    assign cur_tot = cp ? tot[1] : tot[0];
    assign at_goal = cur_tot >= GOAL;
    assign won     = (phase == ST_WON);

    assign die_face = face;
    assign turn_sub = sub;
    assign score_p1 = tot[0];
    assign score_p2 = tot[1];
    assign lamp_p1  = won ? (!cp && blink) : !cp;
    assign lamp_p2  = won ? ( cp && blink) :  cp;

    assert_win_needs_goal_R7: assert property (@(posedge clk) disable iff (rst)
        won |-> cur_tot >= GOAL);
    assert_lamps_differ_R8: assert property (@(posedge clk) disable iff (rst)
        !won |-> (lamp_p1 != lamp_p2));
    assert_bust_keeps_totals_R5: assert property (@(posedge clk) disable iff (rst)
        phase == ST_BUST |=> ($stable(score_p1) && $stable(score_p2)));
    assert_stray_newgame_R9: assert property (@(posedge clk) disable iff (rst)
        (phase != ST_WON && phase != ST_INIT && new_game) |=> phase != ST_INIT);

endmodule

// File: tb/sim_dice_duel_ctrl.sv
`timescale 1ns/1ps
module sim_dice_duel_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       roll = 1'b0, hold = 1'b0, new_game = 1'b0, blink = 1'b0;
    logic [2:0] die_face;
    logic [6:0] turn_sub, score_p1, score_p2;
    logic       lamp_p1, lamp_p2;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    int e_die = 0, e_sub = 0, e_cp = 0;
    int e_tot [2] = '{0, 0};
    bit e_begin = 1'b1;
    bit e_won   = 1'b0;

    always #4 clk = ~clk;

    dice_duel_ctrl u0 (
        .clk(clk), .rst(rst), .roll(roll), .hold(hold), .new_game(new_game),
        .blink(blink), .die_face(die_face), .turn_sub(turn_sub),
        .score_p1(score_p1), .score_p2(score_p2),
        .lamp_p1(lamp_p1), .lamp_p2(lamp_p2)
    );

    function automatic int sat(int a, int b);
        return (a + b > 127) ? 127 : a + b;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_lamps(string req);
        int x1, x2;
        if (e_won) begin
            x1 = (e_cp == 0) ? int'(blink) : 0;
            x2 = (e_cp == 1) ? int'(blink) : 0;
        end else begin
            x1 = (e_cp == 0);
            x2 = (e_cp == 1);
        end
        check({req, " lamp1"}, int'(lamp_p1), x1);
        check({req, " lamp2"}, int'(lamp_p2), x2);
    endtask

    task automatic check_scores(string req);
        check({req, " p1 total"}, int'(score_p1), e_tot[0]);
        check({req, " p2 total"}, int'(score_p2), e_tot[1]);
    endtask

    task automatic roll_to(int t, bit with_hold);
        int k;
        k = (e_die == 0) ? t : (t - e_die + 6) % 6;
        if (k == 0) k = 6;
        roll = 1'b1;
        hold = with_hold;
        @(negedge clk);
        if (e_begin) begin
            e_sub = 0;
            check("R3 subtotal cleared", int'(turn_sub), 0);
        end
        repeat (k) @(negedge clk);
        roll = 1'b0;
        hold = 1'b0;
        @(negedge clk);
        e_die = t;
        check("R2 die face", int'(die_face), e_die);
        if (t == 1) begin
            @(negedge clk);
            e_cp ^= 1;
            e_begin = 1'b1;
            check_scores("R5");
            check_lamps("R5");
        end else begin
            e_sub = sat(e_sub, t);
            e_begin = 1'b0;
            if (with_hold) begin
                check("R6 roll wins over hold", int'(turn_sub), e_sub);
                check_scores("R6 no bank");
            end else
                check("R4 subtotal", int'(turn_sub), e_sub);
        end
    endtask

    task automatic bank();
        hold = 1'b1;
        @(negedge clk);
        hold = 1'b0;
        e_tot[e_cp] = sat(e_tot[e_cp], e_sub);
        check_scores("R6 bank");
        @(negedge clk);
        if (e_tot[e_cp] >= 100)
            e_won = 1'b1;
        else begin
            e_cp ^= 1;
            e_begin = 1'b1;
        end
        check_lamps("R7");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 die", int'(die_face), 0);
        check("R1 subtotal", int'(turn_sub), 0);
        check_scores("R1");
        check_lamps("R1");
        repeat (4) @(negedge clk);
        check("R2 idle die", int'(die_face), 0);

        // game 1, player 1
        roll_to(4, 1'b0);
        roll_to(6, 1'b0);
        repeat (5) @(negedge clk);
        check("R2 die stable while waiting", int'(die_face), 6);
        roll_to(3, 1'b1);
        bank();                       // p1 = 13

        // player 2 rolls 5 then busts
        roll_to(5, 1'b0);
        roll_to(1, 1'b0);
        check("R5 subtotal kept", int'(turn_sub), 5);

        // stray NEW_GAME mid-game
        new_game = 1'b1;
        @(negedge clk);
        new_game = 1'b0;
        @(negedge clk);
        check_scores("R9 ignored");
        check_lamps("R9 ignored");

        // player 1: saturate subtotal and total, win
        for (int i = 0; i < 22; i++) roll_to(6, 1'b0);
        check("R4 subtotal saturates", int'(turn_sub), 127);
        bank();
        check("R7 win", int'(e_won), 1);
        blink = 1'b1;
        #1 check_lamps("R8 blink on");
        blink = 1'b0;
        #1 check_lamps("R8 blink off");

        // new game: totals clear, player 2 opens
        new_game = 1'b1;
        @(negedge clk);
        new_game = 1'b0;
        @(negedge clk);
        e_tot = '{0, 0};
        e_won = 1'b0;
        e_cp = 1;
        e_begin = 1'b1;
        check_scores("R9 new game");
        check_lamps("R9 opener alternates");

        // player 2 reaches 99: no win
        for (int i = 0; i < 16; i++) roll_to(6, 1'b0);
        roll_to(3, 1'b0);
        bank();
        check("R7 99 passes", int'(lamp_p1), 1);
        roll_to(2, 1'b0);
        bank();
        roll_to(2, 1'b0);
        bank();                       // p2 = 101
        check("R7 101 wins", int'(e_won), 1);
        blink = 1'b1;
        #1 check_lamps("R8 p2 winner blink");
        blink = 1'b0;
        #1 check_lamps("R8 p2 winner dark");

        @(negedge clk);
        finish_run();
    end

endmodule